// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a double-data-rate SDRAM command interface. On each rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable, together with the bank select, the address bus, the write byte mask and clock enable. It turns them into one of four decoded commands: open a row, close a bank, read or write. It presents the decoded command on registered outputs: a strobe, the command kind, the bank, the row or column address, an auto-close flag and the byte mask.

For each of four banks it tracks whether the bank is idle or holds an open row, and which row that is. An access that breaks the open/idle rules raises a one-cycle error flag instead of the command strobe and leaves the bank state alone. While clock enable is held low, the whole block freezes: outputs, bank states and any pending auto-close. The data path, strobe timing, mode registers and refresh timing are handled elsewhere.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While rst_n is sampled low, all outputs go to zero on that edge: no strobe, no error, every bank idle, and every stored row cleared to zero.
- R2: A sampled cs_n high is a deselect. cmd_valid and access_err fall to 0, and no bank state or stored row changes.
- R3: cs_n=0, ras_n=0, cas_n=1, we_n=1 is an open-row command (cmd_kind 0). After that edge cmd_bank=ba and cmd_addr=addr. bank_open[ba] is 1 and open_row[ba*12 +: 12] holds addr.
- R4: cs_n=0, ras_n=0, cas_n=1, we_n=0 is a bank close (cmd_kind 1, cmd_addr 0). After that edge bank_open[ba] is 0, and closing an already idle bank is accepted.
- R5: cs_n=0, ras_n=1, cas_n=0 is a column access: we_n=1 gives a read (cmd_kind 2) and we_n=0 gives a write (cmd_kind 3). cmd_addr is addr[8:0] zero-extended, and cmd_autopre equals addr[10].
- R6: On a write, cmd_mask copies dm: bit 0 masks data bits 7:0 and bit 1 masks data bits 15:8. On any other command cmd_mask is 0.
- R7: A read or write to an idle bank, or an open-row command to a bank that is already open, is refused. After that edge access_err=1 and cmd_valid=0, bank state and rows are unchanged, and access_err falls again after the next unfrozen edge that carries no refused command.
- R8: A read or write accepted with addr[10]=1 leaves its bank open right after the command edge and idle after the next unfrozen edge.
- R9: When cke is sampled low at an edge, that edge is still processed. Every later edge leaves all outputs and bank state unchanged, up to and including the edge at which cke is sampled high again. Operation resumes on the edge after that.
- R10: Command codes other than the four above (for example ras_n=0, cas_n=0, or all three strobes high with cs_n low) are ignored: cmd_valid=0, access_err=0, and the banks are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block from the next edge on |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address, or column address with bit 10 as the auto-close request |
| dm | input | 2 | Write byte mask, bit 0 for the low byte and bit 1 for the high byte |
| cmd_valid | output | 1 | Accepted command strobe |
| cmd_kind | output | 2 | 0 open row, 1 close, 2 read, 3 write |
| cmd_bank | output | 2 | Bank of the last decoded command |
| cmd_addr | output | 12 | Row (open) or zero-extended column (read/write) |
| cmd_autopre | output | 1 | Auto-close requested with the read/write |
| cmd_mask | output | 2 | Byte mask of the write |
| access_err | output | 1 | One-cycle flag for a refused command |
| bank_open | output | 4 | Per-bank open flag |
| open_row | output | 48 | Stored row of each bank, bank i in bits i*12 +: 12 |

## Verification
Command results are registered once. The strobe, kind, address fields, error flag and the open/idle state all change on the same edge that samples the command, so the bench drives inputs on the falling edge and checks one falling edge later. An auto-close lands one unfrozen edge after its command, and the bench checks the bank both before and after that edge. For clock enable, the bench counts edges from the one that samples cke low, checks that the held values survive through the edge that samples cke high again, and checks that a command is taken only on the edge after that.

// File: rtl/sdram_cmd_pkg.sv
// Shared types for the SDRAM command tracker.
// Assumes a four-way command set selected by the active-low strobes.
package sdram_cmd_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_PRE = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_kind_t;

    typedef struct packed {
        logic      hit;
        cmd_kind_t kind;
    } dec_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Combinational truth-table decoder for the active-low command strobes.
// Assumes the inputs are the values sampled at the current edge; any code
// outside the four tracked commands yields hit=0.
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output dec_t dec
);

    // Map the strobe pattern onto a command kind.
    always_comb begin
        dec.hit  = 1'b0;
        dec.kind = CMD_ACT;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011: begin dec.hit = 1'b1; dec.kind = CMD_ACT; end
                3'b010: begin dec.hit = 1'b1; dec.kind = CMD_PRE; end
                3'b101: begin dec.hit = 1'b1; dec.kind = CMD_RD;  end
                3'b100: begin dec.hit = 1'b1; dec.kind = CMD_WR;  end
                default: begin dec.hit = 1'b0; dec.kind = CMD_ACT; end
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_slot.sv
// State of one bank: idle/open flag and the stored row.
// Assumes open_req and close_req arrive already gated by clock enable
// and legality, and are never both high in the same cycle.
module sdram_bank_slot #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic [ROW_W-1:0] row_in,
    input  logic             close_req,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);

    // Open or close the bank and capture the row on open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row_q   <= '0;
        end else if (open_req) begin
            is_open <= 1'b1;
            row_q   <= row_in;
        end else if (close_req) begin
            is_open <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Device-side SDRAM command decoder with per-bank open-row tracking.
// Decodes the strobes, checks each access against the bank state, registers
// the decoded command and schedules auto-close one edge after acceptance.
// Assumes one command per edge; a cke sampled low freezes all later edges
// until cke has been sampled high again.
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    parameter int MASK_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]           addr,
    input  logic [MASK_W-1:0]          dm,
    output logic                       cmd_valid,
    output logic [1:0]                 cmd_kind,
    output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    output logic [ROW_W-1:0]           cmd_addr,
    output logic                       cmd_autopre,
    output logic [MASK_W-1:0]          cmd_mask,
    output logic                       access_err,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_row
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int PAD_W  = ROW_W - COL_W;

    dec_t              dec;
    logic              run_en;
    logic              sel_open;
    logic              legal;
    logic              accept;
    logic              refuse;
    logic              ap_pend;
    logic [BANK_W-1:0] ap_bank;
    logic [NUM_BANKS-1:0] open_req;
    logic [NUM_BANKS-1:0] close_req;

    sdram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .dec   (dec)
    );

    // Remember the sampled clock enable; it gates the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_en <= 1'b1;
        else        run_en <= cke;
    end

    // Legality of the decoded command against the addressed bank.
    always_comb begin
        sel_open = bank_open[ba];
        unique case (dec.kind)
            CMD_ACT: legal = !sel_open;
            CMD_PRE: legal = 1'b1;
            default: legal = sel_open;
        endcase
        accept = dec.hit && legal;
        refuse = dec.hit && !legal;
    end

    // Per-bank open/close requests, one slot per bank.
    generate
        for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
            always_comb begin
                open_req[gi]  = run_en && accept && (dec.kind == CMD_ACT)
                                && (ba == BANK_W'(gi));
                close_req[gi] = run_en && ((accept && (dec.kind == CMD_PRE)
                                && (ba == BANK_W'(gi)))
                                || (ap_pend && (ap_bank == BANK_W'(gi))));
            end

            sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .open_req  (open_req[gi]),
                .row_in    (addr),
                .close_req (close_req[gi]),
                .is_open   (bank_open[gi]),
                .row_q     (open_row[gi*ROW_W +: ROW_W])
            );
        end
    endgenerate

    // Register the decoded command and schedule auto-close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid   <= 1'b0;
            access_err  <= 1'b0;
            cmd_kind    <= 2'd0;
            cmd_bank    <= '0;
            cmd_addr    <= '0;
            cmd_autopre <= 1'b0;
            cmd_mask    <= '0;
            ap_pend     <= 1'b0;
            ap_bank     <= '0;
        end else if (run_en) begin
            cmd_valid  <= accept;
            access_err <= refuse;
            ap_pend    <= accept && dec.kind inside {CMD_RD, CMD_WR}
                          && addr[AP_BIT];
            ap_bank    <= ba;
            if (dec.hit) begin
                cmd_kind <= dec.kind;
                cmd_bank <= ba;
                unique case (dec.kind)
                    CMD_ACT: begin
                        cmd_addr    <= addr;
                        cmd_autopre <= 1'b0;
                        cmd_mask    <= '0;
                    end
                    CMD_PRE: begin
                        cmd_addr    <= '0;
                        cmd_autopre <= 1'b0;
                        cmd_mask    <= '0;
                    end
                    CMD_RD: begin
                        cmd_addr    <= {{PAD_W{1'b0}}, addr[COL_W-1:0]};
                        cmd_autopre <= addr[AP_BIT];
                        cmd_mask    <= '0;
                    end
                    default: begin
                        cmd_addr    <= {{PAD_W{1'b0}}, addr[COL_W-1:0]};
                        cmd_autopre <= addr[AP_BIT];
                        cmd_mask    <= dm;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
// Property checker for sdram_cmd_tracker, attached by bind.
// Assumes access to the internal clock-enable state and auto-close pending flag.
module sdram_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int MASK_W    = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cs_n,
    input logic                         run_en,
    input logic                         ap_pend,
    input logic                         cmd_valid,
    input logic [1:0]                   cmd_kind,
    input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input logic [ROW_W-1:0]             cmd_addr,
    input logic                         cmd_autopre,
    input logic [MASK_W-1:0]            cmd_mask,
    input logic                         access_err,
    input logic [NUM_BANKS-1:0]         bank_open,
    input logic [NUM_BANKS*ROW_W-1:0]   open_row
);

    // R1: reset clears strobes and bank state.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !access_err && bank_open == '0 && open_row == '0));

    // R2: deselect produces nothing and touches no bank.
    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && run_en && !ap_pend) |=> (!cmd_valid && !access_err
            && $stable(bank_open) && $stable(open_row)));

    // R3: an accepted open-row command leaves its bank open.
    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0) |-> bank_open[cmd_bank]);

    // R4: an accepted close leaves its bank idle.
    assert_pre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd1) |-> !bank_open[cmd_bank]);

    // R7: a refused open-row command found its bank already open.
    assert_bad_act_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (access_err && cmd_kind == 2'd0) |-> bank_open[cmd_bank]);

    // R8: an auto-close lands on the next unfrozen edge.
    assert_autoclose_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_autopre && run_en) |=> !bank_open[$past(cmd_bank)]);

    // R9: a frozen edge changes no output.
    assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(cmd_valid) && $stable(cmd_kind) && $stable(cmd_bank)
            && $stable(cmd_addr) && $stable(cmd_autopre) && $stable(cmd_mask)
            && $stable(access_err) && $stable(bank_open) && $stable(open_row)));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .MASK_W    (MASK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .run_en      (run_en),
    .ap_pend     (ap_pend),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_bank    (cmd_bank),
    .cmd_addr    (cmd_addr),
    .cmd_autopre (cmd_autopre),
    .cmd_mask    (cmd_mask),
    .access_err  (access_err),
    .bank_open   (bank_open),
    .open_row    (open_row)
);

// File: tb/sdram_cmd_tracker_tb.sv
// Directed bench: inputs change on the falling edge, results are read one
// falling edge later, after the single register stage.
module sdram_cmd_tracker_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [1:0]  dm = '0;
    logic        cmd_valid, cmd_autopre, access_err;
    logic [1:0]  cmd_kind, cmd_bank, cmd_mask;
    logic [11:0] cmd_addr;
    logic [3:0]  bank_open;
    logic [47:0] open_row;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dm(dm),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_autopre(cmd_autopre), .cmd_mask(cmd_mask),
        .access_err(access_err), .bank_open(bank_open), .open_row(open_row)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One edge with the given strobes, then deselect; returns at the falling edge.
    task automatic issue(input logic k, input logic c, input logic r,
                         input logic ca, input logic w, input logic [1:0] b,
                         input logic [11:0] a, input logic [1:0] m);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a; dm = m;
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dm = '0;
    endtask

    task automatic idle(input logic k);
        issue(k, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 12'h000, 2'b00);
    endtask

    task automatic t_reset;
        check("R1", "cmd_valid", cmd_valid, 0);
        check("R1", "access_err", access_err, 0);
        check("R1", "bank_open", bank_open, 0);
        check("R1", "open_row", open_row, 0);
    endtask

    task automatic t_activate;
        issue(1, 0, 0, 1, 1, 2'd1, 12'hABC, 2'b00);
        check("R3", "cmd_valid", cmd_valid, 1);
        check("R3", "cmd_kind", cmd_kind, 0);
        check("R3", "cmd_bank", cmd_bank, 1);
        check("R3", "cmd_addr", cmd_addr, 12'hABC);
        check("R3", "bank_open", bank_open, 4'b0010);
        check("R3", "row1", open_row[23:12], 12'hABC);
    endtask

    task automatic t_deselect;
        issue(1, 1, 0, 1, 1, 2'd2, 12'h111, 2'b00);
        check("R2", "cmd_valid", cmd_valid, 0);
        check("R2", "bank_open", bank_open, 4'b0010);
        check("R2", "row2", open_row[35:24], 0);
    endtask

    task automatic t_read_write;
        issue(1, 0, 1, 0, 1, 2'd1, 12'h9F5, 2'b11);
        check("R5", "rd kind", cmd_kind, 2);
        check("R5", "rd col", cmd_addr, 12'h1F5);
        check("R5", "rd autopre", cmd_autopre, 0);
        check("R6", "rd mask", cmd_mask, 0);
        issue(1, 0, 1, 0, 0, 2'd1, 12'h0AA, 2'b10);
        check("R5", "wr kind", cmd_kind, 3);
        check("R5", "wr valid", cmd_valid, 1);
        check("R6", "wr mask hi", cmd_mask, 2'b10);
        issue(1, 0, 1, 0, 0, 2'd1, 12'h0AA, 2'b01);
        check("R6", "wr mask lo", cmd_mask, 2'b01);
    endtask

    task automatic t_errors;
        issue(1, 0, 1, 0, 1, 2'd3, 12'h010, 2'b00);
        check("R7", "rd idle err", access_err, 1);
        check("R7", "rd idle valid", cmd_valid, 0);
        check("R7", "rd idle banks", bank_open, 4'b0010);
        issue(1, 0, 0, 1, 1, 2'd1, 12'h555, 2'b00);
        check("R7", "act open err", access_err, 1);
        check("R7", "act open row kept", open_row[23:12], 12'hABC);
        idle(1);
        check("R7", "err drops", access_err, 0);
    endtask

    task automatic t_precharge;
        issue(1, 0, 0, 1, 0, 2'd1, 12'hFFF, 2'b00);
        check("R4", "kind", cmd_kind, 1);
        check("R4", "addr", cmd_addr, 0);
        check("R4", "bank_open", bank_open, 0);
        issue(1, 0, 0, 1, 0, 2'd1, 12'h000, 2'b00);
        check("R4", "idle close ok", cmd_valid, 1);
    endtask

    task automatic t_autoclose;
        issue(1, 0, 0, 1, 1, 2'd2, 12'h123, 2'b00);
        issue(1, 0, 1, 0, 0, 2'd2, 12'h433, 2'b00);
        check("R8", "autopre", cmd_autopre, 1);
        check("R5", "col", cmd_addr, 12'h033);
        check("R8", "still open", bank_open[2], 1);
        idle(1);
        check("R8", "closed", bank_open[2], 0);
    endtask

    task automatic t_other_codes;
        issue(1, 0, 1, 1, 1, 2'd0, 12'h000, 2'b00);
        check("R10", "nop valid", cmd_valid, 0);
        issue(1, 0, 0, 0, 1, 2'd0, 12'h000, 2'b00);
        check("R10", "ras+cas valid", cmd_valid, 0);
        check("R10", "ras+cas err", access_err, 0);
        check("R10", "banks", bank_open, 0);
    endtask

    task automatic t_freeze;
        issue(0, 0, 0, 1, 1, 2'd0, 12'h055, 2'b00);
        check("R9", "low edge taken", bank_open[0], 1);
        issue(0, 0, 1, 0, 1, 2'd0, 12'h007, 2'b00);
        check("R9", "frozen kind", cmd_kind, 0);
        check("R9", "frozen valid", cmd_valid, 1);
        issue(1, 0, 1, 0, 1, 2'd0, 12'h007, 2'b00);
        check("R9", "rise edge frozen", cmd_addr, 12'h055);
        issue(1, 0, 1, 0, 1, 2'd0, 12'h007, 2'b00);
        check("R9", "resumed kind", cmd_kind, 2);
        check("R9", "resumed addr", cmd_addr, 12'h007);
        issue(0, 0, 1, 0, 0, 2'd0, 12'h400, 2'b00);
        check("R8", "ap under freeze", cmd_autopre, 1);
        idle(1);
        check("R9", "pending frozen", bank_open[0], 1);
        idle(1);
        check("R8", "pending lands", bank_open[0], 0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_activate();
        t_deselect();
        t_read_write();
        t_errors();
        t_precharge();
        t_autoclose();
        t_other_codes();
        t_freeze();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule